// File: doc/BRIEF.md
# Two-Register Mixing Hash Checker

This core judges one candidate key at a time. The key arrives as a stream of 16-bit chunks. Each chunk folds into two 16-bit accumulators through a byte-swap, XOR and add cross-update. The candidate is accepted once both accumulators equal a pair of fixed target words straight after an update. A chunk of all zeros rejects the candidate. Any chunk after the verdict is settled leaves the accumulators untouched.

A feeding engine drives one chunk per cycle and then a slot-clear strobe on the following cycle. That clear returns the core to its starting state. With the default of three chunks per candidate, a new candidate can therefore begin every four cycles. The verdict comes out as a one-cycle valid pulse with an accept flag, a fixed two cycles after the edge that takes the last chunk. It therefore arrives while the next candidate is already loading. Many such cores can work side by side, each on its own share of the key space.

Top module: `hash_mix_core`

## Requirements
- R1: While reset is asserted and right after it is released, `res_vld` and `acc_ok` are low, and both accumulators, the verdict flags and the chunk count are zero.
- R2: A taken chunk p updates both accumulators together: the new first word is (old second word) XOR swap(p), and the new second word is swap(old first word + swap(p)). The sum is taken modulo 2^16, and swap exchanges bits [15:8] with bits [7:0].
- R3: A candidate is accepted when, after any of its updates, the first word equals 16'hFEB1 and the second word equals 16'h9298. After that, the remaining chunks of that candidate do not change the verdict or the accumulators.
- R4: A taken chunk equal to 16'h0000, arriving before any accept, rejects the candidate and causes no update. The rejection is sticky: later chunks of that candidate neither update the accumulators nor turn the verdict into an accept.
- R5: A candidate is exactly NCHUNK taken chunks (default 3). Chunks presented after the NCHUNK-th one, and before the next slot clear, are ignored and produce no further result.
- R6: If the last chunk is sampled at clock edge k, `res_vld` is high for exactly the one cycle that follows edge k+2. `acc_ok` is low whenever `res_vld` is low.
- R7: `slot_clr` zeroes the accumulators, the verdict flags and the chunk count. A chunk presented in the same cycle as `slot_clr` is dropped.
- R8: A slot clear in the cycle after the last chunk does not cancel or alter the verdict already in flight. The verdict may come out in the same cycle as the first chunk of the next candidate.
- R9: Candidates fed back to back, three chunks and one clear every four cycles, each yield exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chunk | input | 16 | Candidate chunk |
| chunk_vld | input | 1 | Chunk present this cycle |
| slot_clr | input | 1 | Ends the current candidate and clears the core state |
| res_vld | output | 1 | One-cycle pulse marking a verdict |
| acc_ok | output | 1 | Verdict: 1 means accepted; valid only with res_vld |

## Verification
Two things overlap in time in this core. The verdict of one candidate leaves the result pipeline in the same cycle that the slot clear and the first chunk of the next candidate are changing the accumulators. The bench provokes this with long runs of four-cycle candidates. It mixes in hit candidates that it finds by its own search, clears that coincide with chunks, clears in the middle of a candidate, extra trailing chunks and gaps between chunks. Every cycle it compares the pulse and the flag against a verdict that it computed when the last chunk was driven, so a clear that corrupts a verdict in flight, or a chunk that leaks through a clear, shows up as a mismatch.

// File: rtl/hash_mix_pkg.sv
package hash_mix_pkg;

  typedef logic [15:0] word_t;

  typedef struct packed {
    word_t a;
    word_t b;
  } acc_t;

  // exchange the two bytes of a word
  function automatic word_t swap_b(input word_t w);
    return {w[7:0], w[15:8]};
  endfunction

  // one cross-update of the accumulator pair by chunk p
  function automatic acc_t mix_step(input acc_t s, input word_t p);
    acc_t  n;
    word_t ps;
    word_t sum;
    ps  = swap_b(p);
    sum = s.a + ps;
    n.a = s.b ^ ps;
    n.b = swap_b(sum);
    return n;
  endfunction

endpackage

// File: rtl/hmc_slot_ctl.sv
module hmc_slot_ctl #(
  parameter int NCHUNK = 3,
  parameter int CW     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chunk_vld,
  input  logic          slot_clr,
  output logic          take_w,
  output logic          last_w,
  output logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] CNT_END  = CW'(NCHUNK);
  localparam logic [CW-1:0] CNT_LAST = CW'(NCHUNK - 1);

  // the clear wins over a chunk presented with it
  assign take_w = chunk_vld && !slot_clr && (cnt_q < CNT_END);
  assign last_w = take_w && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (slot_clr) cnt_q <= '0;
    else if (take_w)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/hmc_mix_regs.sv
module hmc_mix_regs
  import hash_mix_pkg::*;
#(
  parameter word_t TGT_A = 16'hFEB1,
  parameter word_t TGT_B = 16'h9298
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_clr,
  input  logic  take_w,
  input  word_t chunk,
  output acc_t  acc_q,
  output logic  hit_q,
  output logic  dead_q,
  output logic  zero_w,
  output logic  upd_w
);

  acc_t nxt_w;
  logic open_w;
  logic match_w;

  assign open_w  = !hit_q && !dead_q;
  assign zero_w  = take_w && open_w && (chunk == 16'h0000);
  assign upd_w   = take_w && open_w && (chunk != 16'h0000);
  assign nxt_w   = mix_step(acc_q, chunk);
  assign match_w = (nxt_w.a == TGT_A) && (nxt_w.b == TGT_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hit_q  <= 1'b0;
      dead_q <= 1'b0;
    end else if (slot_clr) begin
      acc_q  <= '0;
      hit_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      if (upd_w) begin
        acc_q <= nxt_w;
        if (match_w) hit_q <= 1'b1;
      end
      if (zero_w) dead_q <= 1'b1;
    end
  end

endmodule

// File: rtl/hmc_result_pipe.sv
module hmc_result_pipe #(
  parameter int RES_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic last_w,
  input  logic hit_q,
  output logic res_vld,
  output logic acc_ok
);

  logic fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else        fin_q <= last_w;
  end

  // the verdict is captured one edge after the last chunk, before a clear lands
  for (genvar i = 0; i < RES_LAT; i++) begin : g_st
    logic [1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 2'b00;
        else        q <= {fin_q, fin_q & hit_q};
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 2'b00;
        else        q <= g_st[i-1].q;
      end
    end
  end

  assign {res_vld, acc_ok} = g_st[RES_LAT-1].q;

endmodule

// File: rtl/hash_mix_core.sv
module hash_mix_core
  import hash_mix_pkg::*;
#(
  parameter int    NCHUNK = 3,
  parameter word_t TGT_A  = 16'hFEB1,
  parameter word_t TGT_B  = 16'h9298
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] chunk,
  input  logic        chunk_vld,
  input  logic        slot_clr,
  output logic        res_vld,
  output logic        acc_ok
);

  localparam int CW      = $clog2(NCHUNK + 1);
  localparam int RES_LAT = 2;

  logic          take_w;
  logic          last_w;
  logic [CW-1:0] cnt_q;
  acc_t          acc_q;
  logic          hit_q;
  logic          dead_q;
  logic          zero_w;
  logic          upd_w;
  word_t         acc_a;
  word_t         acc_b;

  assign acc_a = acc_q.a;
  assign acc_b = acc_q.b;

  hmc_slot_ctl #(.NCHUNK(NCHUNK), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .chunk_vld(chunk_vld), .slot_clr(slot_clr),
    .take_w(take_w), .last_w(last_w), .cnt_q(cnt_q)
  );

  hmc_mix_regs #(.TGT_A(TGT_A), .TGT_B(TGT_B)) u_mix (
    .clk(clk), .rst_n(rst_n), .slot_clr(slot_clr), .take_w(take_w),
    .chunk(chunk), .acc_q(acc_q), .hit_q(hit_q), .dead_q(dead_q),
    .zero_w(zero_w), .upd_w(upd_w)
  );

  hmc_result_pipe #(.RES_LAT(RES_LAT)) u_res (
    .clk(clk), .rst_n(rst_n), .last_w(last_w), .hit_q(hit_q),
    .res_vld(res_vld), .acc_ok(acc_ok)
  );

endmodule

// File: rtl/hash_mix_core_chk.sv
module hash_mix_core_chk #(
  parameter int NCHUNK = 3,
  parameter int CW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slot_clr,
  input logic          last_w,
  input logic          zero_w,
  input logic          upd_w,
  input logic          hit_q,
  input logic          dead_q,
  input logic [15:0]   acc_a,
  input logic [15:0]   acc_b,
  input logic [CW-1:0] cnt_q,
  input logic          res_vld,
  input logic          acc_ok
);

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld); // R6
  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !acc_ok); // R6
  AST_RESULT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |-> ##3 res_vld); // R6
  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    slot_clr |=> (acc_a == 16'h0 && acc_b == 16'h0 && !hit_q && !dead_q && cnt_q == '0)); // R7
  AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_w |=> dead_q); // R4
  AST_DEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_q && !slot_clr) |=> (dead_q && $stable(acc_a) && $stable(acc_b))); // R4
  AST_HIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !slot_clr) |=> (hit_q && $stable(acc_a) && $stable(acc_b))); // R3
  AST_UPD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_w && zero_w)); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NCHUNK)); // R5

endmodule

bind hash_mix_core hash_mix_core_chk #(.NCHUNK(NCHUNK), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_clr(slot_clr), .last_w(last_w),
  .zero_w(zero_w), .upd_w(upd_w), .hit_q(hit_q), .dead_q(dead_q),
  .acc_a(acc_a), .acc_b(acc_b), .cnt_q(cnt_q), .res_vld(res_vld), .acc_ok(acc_ok)
);

// File: tb/tb_hash_mix_core.sv
module tb_hash_mix_core;

  localparam int NCH = 3;
  localparam int TA  = 'hFEB1;
  localparam int TB  = 'h9298;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chunk = '0;
  logic        chunk_vld = 1'b0;
  logic        slot_clr = 1'b0;
  wire         res_vld;
  wire         acc_ok;

  always #4 clk = ~clk;

  hash_mix_core dut (
    .clk(clk), .rst_n(rst_n), .chunk(chunk), .chunk_vld(chunk_vld),
    .slot_clr(slot_clr), .res_vld(res_vld), .acc_ok(acc_ok)
  );

  int n_cmp = 0, n_bad = 0, done = 0;
  int exp_hits = 0, got_hits = 0, got_res = 0, drv_res = 0, drv_k = 0;
  int nh = 0;
  int h0 [8];
  int h1 [8];
  int h2 [8];
  int rs = 32'h1234_5679;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench-side arithmetic, stated with integers
  function automatic int sw(input int w);
    return ((w % 256) * 256) + (w / 256);
  endfunction

  function automatic void step(inout int a, inout int b, input int p);
    int ps, na;
    ps = sw(p);
    na = b ^ ps;
    b  = sw((a + ps) % 65536);
    a  = na;
  endfunction

  function automatic int rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >>> 17);
    rs = rs ^ (rs << 5);
    return rs & 32'h7fff_ffff;
  endfunction

  // reference model and verdict pipe, advanced from the inputs sampled at each edge
  int m_a = 0, m_b = 0, m_hit = 0, m_dead = 0, m_cnt = 0;
  int q1v = 0, q1a = 0, q2v = 0, q2a = 0;

  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      chk(res_vld == 1'b0 && acc_ok == 1'b0, "R1 outputs in reset", {res_vld, acc_ok}, 0);
      m_a = 0; m_b = 0; m_hit = 0; m_dead = 0; m_cnt = 0;
      q1v = 0; q1a = 0; q2v = 0; q2a = 0;
    end else begin
      chk(res_vld == q1v[0], "R6 result pulse timing", res_vld, q1v);
      if (q1v != 0) chk(acc_ok == q1a[0], "R3 verdict", acc_ok, q1a);
      else          chk(acc_ok == 1'b0, "R6 flag low without valid", acc_ok, 0);
      if (res_vld) got_res++;
      if (res_vld && acc_ok) got_hits++;
      q1v = q2v; q1a = q2a; q2v = 0; q2a = 0;
      if (slot_clr) begin
        m_a = 0; m_b = 0; m_hit = 0; m_dead = 0; m_cnt = 0;
      end else if (chunk_vld && m_cnt < NCH) begin
        if (m_hit == 0 && m_dead == 0) begin
          if (chunk == 16'h0) m_dead = 1;
          else begin
            step(m_a, m_b, int'(chunk));
            if (m_a == TA && m_b == TB) m_hit = 1;
          end
        end
        m_cnt++;
        if (m_cnt == NCH) begin
          q2v = 1; q2a = m_hit;
          if (m_hit != 0) exp_hits++;
        end
      end
    end
  end

  task automatic put(input int p);
    @(negedge clk);
    chunk = p[15:0]; chunk_vld = 1'b1; slot_clr = 1'b0;
    if (drv_k < NCH) begin
      drv_k++;
      if (drv_k == NCH) drv_res++;
    end
  endtask

  task automatic clr();
    @(negedge clk);
    chunk_vld = 1'b0; slot_clr = 1'b1; drv_k = 0;
  endtask

  task automatic clr_with(input int p);
    @(negedge clk);
    chunk = p[15:0]; chunk_vld = 1'b1; slot_clr = 1'b1; drv_k = 0;
  endtask

  task automatic gap();
    @(negedge clk);
    chunk_vld = 1'b0; slot_clr = 1'b0;
  endtask

  task automatic cand(input int p0, input int p1, input int p2);
    put(p0); put(p1); put(p2); clr();
  endtask

  function automatic bit hits3(input int p0, input int p1, input int p2);
    int a, b;
    a = 0; b = 0;
    if (p0 == 0) return 0;
    step(a, b, p0);
    if (a == TA && b == TB) return 1;
    if (p1 == 0) return 0;
    step(a, b, p1);
    if (a == TA && b == TB) return 1;
    if (p2 == 0) return 0;
    step(a, b, p2);
    return (a == TA && b == TB);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (done == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // hit search (R2, R3): two-chunk solutions, then three-chunk ones
    for (int x = 0; x < 65536 && nh < 3; x++) begin
      int p1, p2;
      p1 = TA ^ x; p2 = sw(x);
      if (p1 != 0 && p2 != 0 && hits3(p1, p2, 0)) begin
        h0[nh] = p1; h1[nh] = p2; h2[nh] = 0; nh++;
      end
    end
    for (int p0 = 1; p0 < 17 && nh < 8; p0++) begin
      for (int p1 = 1; p1 < 65536 && nh < 8; p1++) begin
        int a, b, p2;
        a = 0; b = 0;
        step(a, b, p0 * 4099 % 65536); step(a, b, p1);
        p2 = sw(b ^ TA);
        if (p2 != 0 && hits3(p0 * 4099 % 65536, p1, p2)) begin
          h0[nh] = p0 * 4099 % 65536; h1[nh] = p1; h2[nh] = p2; nh++;
        end
      end
    end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(res_vld == 1'b0 && acc_ok == 1'b0, "R1 after release", {res_vld, acc_ok}, 0);

    // R1 R2 R3: first candidate after reset starts from zero accumulators
    if (nh > 0) cand(h0[0], h1[0], h2[0]);

    // sweep with mixed patterns (R2 R4 R5 R7 R8 R9)
    for (int i = 0; i < 3000; i++) begin
      int c [3];
      for (int j = 0; j < 3; j++) begin
        c[j] = rnd() % 65536;
        if (rnd() % 12 == 0) c[j] = 0;
      end
      if (nh > 0 && i % 20 == 0) begin
        c[0] = h0[i / 20 % nh]; c[1] = h1[i / 20 % nh]; c[2] = h2[i / 20 % nh];
        if (i % 40 == 0) c[2] = c[2] ^ 1; // near miss on three-chunk hits
      end
      put(c[0]);
      if (i % 7 == 0) gap();
      put(c[1]);
      put(c[2]);
      if (i % 11 == 0) begin put(rnd() % 65536); put(0); end // R5 trailing chunks
      if (i % 13 == 0) gap();
      if (i % 17 == 0) clr_with(rnd() % 65536);              // R7 clear with chunk
      else clr();
    end

    if (nh > 0) begin
      // R4: zero first, then a hit pair in later slots stays rejected
      cand(0, h0[0], h1[0]);
      // R3 R4: zero after an accept has no effect
      cand(h0[0], h1[0], 0);
      // R7: aborted candidate, then a clear carrying a chunk, then a hit
      put(h0[0]); clr(); clr_with(h0[0]);
      cand(h0[0], h1[0], h2[0]);
      // R5: extra chunks past the last, then the next candidate is clean
      put(5); put(6); put(7); put(h0[0]); put(h1[0]); clr();
      cand(h0[0], h1[0], h2[0]);
      // R8 R9: back to back hits, verdict overlapping the next first chunk
      for (int k = 0; k < 6; k++) cand(h0[k % nh], h1[k % nh], h2[k % nh]);
    end

    gap(); gap(); gap(); gap();
    @(posedge clk); #3;
    chk(nh > 0, "R3 hit candidates found", nh, 1);
    chk(got_hits == exp_hits && exp_hits > 0, "R3 accepted count", got_hits, exp_hits);
    chk(got_res == drv_res, "R9 result count", got_res, drv_res);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule